// File: doc/BRIEF.md
# Sequential Restoring-Free Binary Divider

This block divides an unsigned 2W-bit dividend by an unsigned W-bit divisor and returns a W-bit quotient and a W-bit remainder. A start pulse loads the top half of the dividend into a high work register and the bottom half into a low work register. The divisor goes into a register of its own. The block then runs one step per clock for W clocks. In each step the register pair moves one place to the left. The high half is compared with the divisor, and the divisor is subtracted only when it fits. The resulting quotient bit is written into the bit position that the shift left empty at the bottom of the low half.

When all steps are done, the high register holds the remainder and the low register holds the quotient. These are the values on `remainder_o` and `quotient_o`. The block refuses a request whose quotient would not fit in W bits. That covers a zero divisor, and an upper dividend half that is already greater than or equal to the divisor. For such a request it raises an error flag, ends at once and leaves the result outputs untouched.

Top module: `seq_divider`

## Requirements
- R1: After reset `busy_o`, `done_o` and `error_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A valid start sampled at clock edge k raises `busy_o` after edge k. `done_o` is then high during exactly the cycle after edge k+W, which is W steps later.
- R3: For a valid request, `quotient_o` is floor(dividend / divisor) and `remainder_o` is dividend mod divisor while `done_o` is high. Both operands are unsigned, and dividend bits [2W-1:W] form the high half.
- R4: While `done_o` is high without `error_o`, `remainder_o` is strictly less than the divisor that was loaded.
- R5: A partial remainder whose shift pushes a 1 out of the high register's MSB always counts as greater than or equal to the divisor, so divisors with their MSB set give correct results.
- R6: `done_o` is a single-cycle pulse, and `busy_o` is 0 whenever `done_o` is 1.
- R7: A start with divisor 0 gives `done_o` and `error_o` high in the cycle after the start edge, with `busy_o` kept low and the result outputs unchanged.
- R8: A start whose dividend high half is greater than or equal to a nonzero divisor behaves as in R7. A high half of exactly divisor-1 is accepted.
- R9: `start_i` while `busy_o` is high is ignored: the running division's result and its completion cycle do not change.
- R10: `error_o` stays high after a rejected request until the next accepted start. A valid start clears it from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (sampled only when idle) |
| dividend_i | input | 2W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| quotient_o | output | W | Quotient (valid while done_o is high) |
| remainder_o | output | W | Remainder (valid while done_o is high) |
| busy_o | output | 1 | Steps still in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Last request refused (zero divisor or quotient overflow) |

## Verification
The bench targets the divisor of all ones. Here the shifted partial remainder leaves a 1 past the register width, and a design without the extra comparison bit would skip a subtraction and return a wrong quotient. It also probes the overflow boundary: a high half equal to the divisor must be refused, and one less must be accepted. A design that compares with `>` instead of `>=` would start a division whose quotient wraps. A start pulse injected mid-run checks that the operands are not reloaded and that the completion cycle does not move. The bench also checks that a refused request does not disturb the previously returned quotient and remainder.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_guard.sv
module div_guard #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] divisor_i,
  output logic         reject_o
);
  logic zero_div;
  logic too_big;

  assign zero_div = (divisor_i == '0);
  assign too_big  = (hi_i >= divisor_i);
  assign reject_o = zero_div | too_big;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         qbit_o
);
  logic         spill;
  logic [W-1:0] hi_sh;
  logic         fits;

  // shift the pair left; the bit leaving hi is kept as an extra compare bit
  assign {spill, hi_sh} = {hi_i, lo_i[W-1]};
  assign fits   = spill | (hi_sh >= div_i);
  // with spill set, the true value is < 2*div, so the wrapped difference is exact
  assign hi_o   = fits ? (hi_sh - div_i) : hi_sh;
  assign lo_o   = {lo_i[W-2:0], fits};
  assign qbit_o = fits;
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic reject_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load_o = accept && !reject_i;
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        if (reject_i) begin
          done_o  <= 1'b1;
          error_o <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
          error_o <= 1'b0;
        end
      end else if (state_q == ST_RUN) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*W-1:0] dividend_i,
  input  logic [W-1:0]   divisor_i,
  output logic [W-1:0]   quotient_o,
  output logic [W-1:0]   remainder_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           error_o
);
  logic [W-1:0] hi_q, lo_q, div_q;
  logic [W-1:0] hi_nx, lo_nx;
  logic         qbit;
  logic         reject, load, step;

  div_guard #(.W(W)) i_guard (
    .hi_i      (dividend_i[2*W-1:W]),
    .divisor_i (divisor_i),
    .reject_o  (reject)
  );

  div_step #(.W(W)) i_step (
    .hi_i   (hi_q),
    .lo_i   (lo_q),
    .div_i  (div_q),
    .hi_o   (hi_nx),
    .lo_o   (lo_nx),
    .qbit_o (qbit)
  );

  div_ctrl #(.W(W)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .reject_i (reject),
    .load_o   (load),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .error_o  (error_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      div_q <= '0;
    end else if (load) begin
      hi_q  <= dividend_i[2*W-1:W];
      lo_q  <= dividend_i[W-1:0];
      div_q <= divisor_i;
    end else if (step) begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
    end
  end

  assign quotient_o  = lo_q;
  assign remainder_o = hi_q;
endmodule

// File: rtl/div_checks.sv
module div_checks #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         load,
  input logic         busy_o,
  input logic         done_o,
  input logic         error_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic [W-1:0] div_q
);
  localparam int CW = $clog2(W + 1) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (load)   run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
  end

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o) |-> (run_cnt == CW'(W)));

  assert_rem_below_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o) |-> (remainder_o < div_q));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_reject_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && error_o) |-> ($stable(quotient_o) && $stable(remainder_o)));

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(div_q));

  assert_fall_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && !error_o));
endmodule

bind seq_divider div_checks #(.W(W)) i_div_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .load        (load),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .div_q       (div_q)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2*W-1:0] dividend = '0;
  logic [W-1:0]   divisor = '0;
  logic [W-1:0]   quotient, remainder;
  logic           busy, done, error;

  int n_chk = 0;
  int n_err = 0;
  logic [W-1:0] q_last = '0;
  logic [W-1:0] r_last = '0;

  always #2.5 clk = ~clk;

  seq_divider #(.W(W)) i_seq_divider (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .quotient_o  (quotient),
    .remainder_o (remainder),
    .busy_o      (busy),
    .done_o      (done),
    .error_o     (error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Valid request; optional stray start injected mid-run at step `poke`
  task automatic run_div(input string req, input logic [2*W-1:0] dd,
                         input logic [W-1:0] dv, input int poke);
    logic [W-1:0] q_exp, r_exp;
    q_exp = W'(dd / dv);
    r_exp = W'(dd % dv);
    @(negedge clk);
    start = 1'b1; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R2 busy after start"}, busy, 1);
    chk({req, " R10 error cleared"}, error, 0);
    for (int i = 1; i < W; i++) begin
      if (i == poke) begin
        start = 1'b1; dividend = 16'h0102; divisor = 8'h03;
      end
      @(negedge clk);
      start = 1'b0;
      chk({req, " R2 no early done"}, done, 0);
    end
    @(negedge clk);
    chk({req, " R2 done at step W"}, done, 1);
    chk({req, " R6 busy low on done"}, busy, 0);
    chk({req, " R3 quotient"}, quotient, q_exp);
    chk({req, " R3 remainder"}, remainder, r_exp);
    chk({req, " R4 remainder below divisor"}, remainder < dv, 1);
    q_last = q_exp; r_last = r_exp;
    @(negedge clk);
    chk({req, " R6 done single pulse"}, done, 0);
  endtask

  task automatic run_reject(input string req, input logic [2*W-1:0] dd,
                            input logic [W-1:0] dv);
    @(negedge clk);
    start = 1'b1; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done at once"}, done, 1);
    chk({req, " error set"}, error, 1);
    chk({req, " busy stays low"}, busy, 0);
    chk({req, " quotient unchanged"}, quotient, q_last);
    chk({req, " remainder unchanged"}, remainder, r_last);
    @(negedge clk);
    chk({req, " R6 done single pulse"}, done, 0);
    repeat (3) @(negedge clk);
    chk("R10 error sticky", error, 1);
  endtask

  initial begin
    #20000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 error reset", error, 0);
    chk("R1 quotient reset", quotient, 0);
    chk("R1 remainder reset", remainder, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_div("R3 61/9", 16'd61, 8'd9, 0);
    run_div("R3 by one", 16'h00AB, 8'd1, 0);
    run_div("R5 msb divisor", 16'hFEFF, 8'hFF, 0);
    run_div("R5 msb divisor b", 16'h80FF, 8'h81, 0);
    run_div("R3 exact", 16'd1000, 8'd8, 0);
    run_reject("R7 zero divisor", 16'h1234, 8'h00);
    run_reject("R8 high equals divisor", 16'h2A00, 8'h2A);
    run_reject("R8 high above divisor", 16'hF000, 8'h10);
    run_div("R8 high one below", 16'h29FF, 8'h2A, 0);
    run_div("R9 start while busy", 16'h3C5A, 8'h77, 3);
    run_div("R9 start late in run", 16'h0FFF, 8'h13, W - 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule